// File: doc/BRIEF.md
# Asynchronous SRAM Interface Controller

The controller lets a clocked host read and write a 32K x 8 asynchronous static RAM. The host raises a request with an address, a read/write flag and, for writes, a data byte. It holds these until the controller answers with a one-cycle acknowledge. For reads, the returned byte sits on the read-data output from that acknowledge until the next read completes.

On the memory side the block drives active-low chip select, write enable and output enable, plus the address bus. The bidirectional data pins are handled as three signals: data out, data in and a drive enable. The pad buffer that joins them lives outside this block. All strobes and the drive enable come straight from flops. The lengths of the read access, the write pulse and the bus turnaround are set in whole clock cycles. The block works them out by rounding the memory's nanosecond timing figures up to the configured clock period.

The address changes only while chip select is high. Output enable is held high during writes. The write pulse is still sized for the slower case in which output enable is held low, so the data setup time is met even when the memory's output drivers still have to turn off.

Top module: `sram_async_ctrl`

## Requirements
- R1: After reset, and whenever no transaction is in flight, sram_cs_n_o, sram_we_n_o and sram_oe_n_o are 1, sram_dq_oe_o is 0 and ack_o is 0.
- R2: sram_addr_o changes only on a clock edge at which sram_cs_n_o was 1, so it never changes while chip select is active.
- R3: A read asserts chip select for one setup cycle with output enable high. It then holds output enable low for exactly RD_CYC = ceil(T_AA_NS/CLK_NS) cycles. The byte on sram_dq_i at the end of the last of those cycles is returned on rdata_o.
- R4: A write holds sram_we_n_o low for exactly WP_CYC cycles, with sram_oe_n_o high and sram_cs_n_o low throughout. WP_CYC = max(ceil(T_WP_NS/CLK_NS), ceil((T_WHZ_NS+T_DW_NS)/CLK_NS)).
- R5: sram_dq_oe_o is 1 exactly in the cycles where sram_we_n_o is 0, and sram_dq_o then carries the requested write byte. The bus is released on the same edge at which write enable rises.
- R6: After sram_oe_n_o rises, sram_dq_oe_o stays 0 for at least TA_CYC = ceil(T_OHZ_NS/CLK_NS) cycles.
- R7: Every transaction ends with ack_o high for exactly one cycle. This comes RD_CYC+1 cycles (read) or WP_CYC+1 cycles (write) after chip select first goes low.
- R8: A byte written to an address is returned by a later read of that address, across the whole 15-bit address range, including addresses 0, 0x7FFF and every single-bit address.
- R9: rdata_o keeps its value through write transactions and changes only when a read completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Host request, held until ack_o |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | AW | Host byte address |
| wdata_i | input | DW | Host write byte |
| ack_o | output | 1 | One-cycle completion pulse |
| rdata_o | output | DW | Last byte read |
| sram_cs_n_o | output | 1 | Memory chip select, active low |
| sram_we_n_o | output | 1 | Memory write enable, active low |
| sram_oe_n_o | output | 1 | Memory output enable, active low |
| sram_addr_o | output | AW | Memory address |
| sram_dq_o | output | DW | Data toward the pads |
| sram_dq_i | input | DW | Data from the pads |
| sram_dq_oe_o | output | 1 | Pad drive enable |

## Verification
The assertions assume that the host keeps req_i, we_i, addr_i and wdata_i steady from raising the request until it sees ack_o. They also assume the host lowers req_i in the acknowledge cycle, so that one request never starts two transactions. The bench drives all host inputs at the falling edge and follows exactly this protocol. It attaches a behavioural memory stub that returns a poison byte until output enable has been low for the full access time. The stub flags address movement under an active select, wrong strobe lengths and drive too soon after output enable rises.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_READ_WAIT,
    ST_READ_CAPTURE,
    ST_WRITE_PULSE,
    ST_WRITE_RECOVER,
    ST_TURNAROUND
  } ctrl_state_e;

  typedef struct packed {
    logic cs_n;
    logic we_n;
    logic oe_n;
    logic dq_oe;
    logic ack;
  } strobe_t;

  function automatic int cdiv(input int num, input int den);
    return (num + den - 1) / den;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  function automatic strobe_t strobe_of(input ctrl_state_e st);
    strobe_t s;
    s = '{cs_n: 1'b1, we_n: 1'b1, oe_n: 1'b1, dq_oe: 1'b0, ack: 1'b0};
    unique case (st)
      ST_SETUP:         s.cs_n = 1'b0;
      ST_READ_WAIT:     begin s.cs_n = 1'b0; s.oe_n = 1'b0; end
      ST_READ_CAPTURE:  s.ack = 1'b1;
      ST_WRITE_PULSE:   begin s.cs_n = 1'b0; s.we_n = 1'b0; s.dq_oe = 1'b1; end
      ST_WRITE_RECOVER: s.ack = 1'b1;
      default:          ;
    endcase
    return s;
  endfunction

endpackage

// File: rtl/sram_phase_cnt.sv
module sram_phase_cnt #(
  parameter int CW = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [CW-1:0] load_val_i,
  output logic          done_o
);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (load_i)        cnt_q <= load_val_i;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign done_o = (cnt_q == '0);

endmodule

// File: rtl/sram_data_path.sv
module sram_data_path #(
  parameter int AW = 15,
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          accept_i,
  input  logic          capture_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [DW-1:0] dq_i,
  output logic [AW-1:0] addr_o,
  output logic [DW-1:0] dq_o,
  output logic [DW-1:0] rdata_o
);

  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdata_q;
  logic [DW-1:0] rdata_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (accept_i) begin
      addr_q  <= addr_i;
      wdata_q <= wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        rdata_q <= '0;
    else if (capture_i) rdata_q <= dq_i;
  end

  assign addr_o  = addr_q;
  assign dq_o    = wdata_q;
  assign rdata_o = rdata_q;

  // R9: read data only moves on a capture
  a_r9_rdata_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(capture_i) |-> $stable(rdata_o));

endmodule

// File: rtl/sram_ctrl_fsm.sv
module sram_ctrl_fsm
  import sram_ctrl_pkg::*;
#(
  parameter int RD_CYC = 2,
  parameter int WP_CYC = 3,
  parameter int TA_CYC = 1,
  parameter int CW     = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  input  logic          wr_i,
  input  logic          done_i,
  output logic          load_o,
  output logic [CW-1:0] load_val_o,
  output logic          accept_o,
  output logic          capture_o,
  output logic          cs_n_o,
  output logic          we_n_o,
  output logic          oe_n_o,
  output logic          dq_oe_o,
  output logic          ack_o
);

  localparam logic [CW-1:0] RD_LD = CW'(RD_CYC - 1);
  localparam logic [CW-1:0] WP_LD = CW'(WP_CYC - 1);
  localparam logic [CW-1:0] TA_LD = CW'(TA_CYC - 1);

  ctrl_state_e state_q, state_d;
  logic        is_wr_q;
  strobe_t     strb_q;

  always_comb begin
    state_d    = state_q;
    load_o     = 1'b0;
    load_val_o = '0;
    accept_o   = 1'b0;
    capture_o  = 1'b0;
    unique case (state_q)
      ST_IDLE: if (req_i) begin
        accept_o = 1'b1;
        state_d  = ST_SETUP;
      end
      ST_SETUP: begin
        load_o = 1'b1;
        if (is_wr_q) begin
          load_val_o = WP_LD;
          state_d    = ST_WRITE_PULSE;
        end else begin
          load_val_o = RD_LD;
          state_d    = ST_READ_WAIT;
        end
      end
      ST_READ_WAIT: if (done_i) begin
        capture_o = 1'b1;
        state_d   = ST_READ_CAPTURE;
      end
      ST_READ_CAPTURE: begin
        load_o     = 1'b1;
        load_val_o = TA_LD;
        state_d    = ST_TURNAROUND;
      end
      ST_WRITE_PULSE:   if (done_i) state_d = ST_WRITE_RECOVER;
      ST_WRITE_RECOVER: state_d = ST_IDLE;
      ST_TURNAROUND:    if (done_i) state_d = ST_IDLE;
      default:          state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      is_wr_q <= 1'b0;
      strb_q  <= '{cs_n: 1'b1, we_n: 1'b1, oe_n: 1'b1, dq_oe: 1'b0, ack: 1'b0};
    end else begin
      state_q <= state_d;
      if (accept_o) is_wr_q <= wr_i;
      // strobes registered from next state: glitch-free pins
      strb_q  <= strobe_of(state_d);
    end
  end

  assign cs_n_o  = strb_q.cs_n;
  assign we_n_o  = strb_q.we_n;
  assign oe_n_o  = strb_q.oe_n;
  assign dq_oe_o = strb_q.dq_oe;
  assign ack_o   = strb_q.ack;

  // checker counters
  logic [CW:0] we_lo_cnt_q;
  logic [CW:0] oe_hi_cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      we_lo_cnt_q <= '0;
      oe_hi_cnt_q <= (CW+1)'(TA_CYC);
    end else begin
      if (we_n_o)                   we_lo_cnt_q <= '0;
      else if (we_lo_cnt_q != '1)   we_lo_cnt_q <= we_lo_cnt_q + 1'b1;
      if (!oe_n_o)                  oe_hi_cnt_q <= '0;
      else if (oe_hi_cnt_q < (CW+1)'(TA_CYC)) oe_hi_cnt_q <= oe_hi_cnt_q + 1'b1;
    end
  end

  a_r4_wp_len: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(we_n_o) |-> (we_lo_cnt_q >= (CW+1)'(WP_CYC)));

  a_r4_oe_off_in_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_n_o |-> (oe_n_o && !cs_n_o));

  a_r5_drive_with_we: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dq_oe_o == !we_n_o);

  a_r6_turnaround: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(dq_oe_o) |-> (oe_hi_cnt_q >= (CW+1)'(TA_CYC)));

  a_r7_ack_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |=> !ack_o);

  a_r1_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_n_o |-> (we_n_o && oe_n_o && !dq_oe_o));

endmodule

// File: rtl/sram_async_ctrl.sv
module sram_async_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int AW        = 15,
  parameter int DW        = 8,
  parameter int CLK_NS    = 10,
  parameter int T_AA_NS   = 20,
  parameter int T_WP_NS   = 15,
  parameter int T_DW_NS   = 11,
  parameter int T_WHZ_NS  = 10,
  parameter int T_OHZ_NS  = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic          ack_o,
  output logic [DW-1:0] rdata_o,
  output logic          sram_cs_n_o,
  output logic          sram_we_n_o,
  output logic          sram_oe_n_o,
  output logic [AW-1:0] sram_addr_o,
  output logic [DW-1:0] sram_dq_o,
  input  logic [DW-1:0] sram_dq_i,
  output logic          sram_dq_oe_o
);

  localparam int RD_CYC = imax(1, cdiv(T_AA_NS, CLK_NS));
  // pulse sized for output enable held low: covers driver turn-off + setup
  localparam int WP_CYC = imax(imax(1, cdiv(T_WP_NS, CLK_NS)),
                               cdiv(T_WHZ_NS + T_DW_NS, CLK_NS));
  localparam int TA_CYC = imax(1, cdiv(T_OHZ_NS, CLK_NS));
  localparam int CW     = $clog2(imax(imax(RD_CYC, WP_CYC), TA_CYC) + 1);

  logic          load;
  logic [CW-1:0] load_val;
  logic          done;
  logic          accept;
  logic          capture;

  sram_phase_cnt #(.CW(CW)) u_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (load),
    .load_val_i (load_val),
    .done_o     (done)
  );

  sram_ctrl_fsm #(
    .RD_CYC (RD_CYC),
    .WP_CYC (WP_CYC),
    .TA_CYC (TA_CYC),
    .CW     (CW)
  ) u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .req_i      (req_i),
    .wr_i       (we_i),
    .done_i     (done),
    .load_o     (load),
    .load_val_o (load_val),
    .accept_o   (accept),
    .capture_o  (capture),
    .cs_n_o     (sram_cs_n_o),
    .we_n_o     (sram_we_n_o),
    .oe_n_o     (sram_oe_n_o),
    .dq_oe_o    (sram_dq_oe_o),
    .ack_o      (ack_o)
  );

  sram_data_path #(.AW(AW), .DW(DW)) u_dp (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .accept_i  (accept),
    .capture_i (capture),
    .addr_i    (addr_i),
    .wdata_i   (wdata_i),
    .dq_i      (sram_dq_i),
    .addr_o    (sram_addr_o),
    .dq_o      (sram_dq_o),
    .rdata_o   (rdata_o)
  );

  a_r2_addr_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sram_addr_o) |-> $past(sram_cs_n_o));

  a_r3_capture_in_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    capture |-> (!sram_oe_n_o && !sram_cs_n_o && sram_we_n_o));

endmodule

// File: tb/sim_sram_async_ctrl.sv
module sim_sram_async_ctrl;

  localparam int CLK_NS = 10;
  localparam int AW = 15;
  localparam int DW = 8;
  localparam int RD_EXP = (20 + CLK_NS - 1) / CLK_NS;
  localparam int WPA    = (15 + CLK_NS - 1) / CLK_NS;
  localparam int WPB    = (10 + 11 + CLK_NS - 1) / CLK_NS;
  localparam int WP_EXP = (WPA > WPB) ? WPA : WPB;
  localparam int TA_EXP = (8 + CLK_NS - 1) / CLK_NS;
  localparam int NADDR  = 81;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req = 1'b0;
  logic          we = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic          ack;
  logic [DW-1:0] rdata;
  logic          cs_n, we_n, oe_n, dq_oe;
  logic [AW-1:0] m_addr;
  logic [DW-1:0] dq_o;
  logic [DW-1:0] dq_i;

  int nvec = 0;
  int nfail = 0;
  bit finished = 0;

  always #(CLK_NS/2) clk = ~clk;

  sram_async_ctrl #(.CLK_NS(CLK_NS)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .ack_o(ack), .rdata_o(rdata), .sram_cs_n_o(cs_n),
    .sram_we_n_o(we_n), .sram_oe_n_o(oe_n), .sram_addr_o(m_addr),
    .sram_dq_o(dq_o), .sram_dq_i(dq_i), .sram_dq_oe_o(dq_oe)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    nvec++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // behavioural memory stub
  logic [DW-1:0] mem [logic [AW-1:0]];
  logic [DW-1:0] exp_mem [logic [AW-1:0]];
  int oe_lo_cnt = 0, we_lo_cnt = 0, oe_hi_cnt = 100;
  logic p_cs_n = 1, p_we_n = 1, p_oe_n = 1, p_dq_oe = 0;
  logic [AW-1:0] p_addr = '0;
  logic [DW-1:0] p_dq = '0;

  function automatic logic [DW-1:0] mem_rd(input logic [AW-1:0] a);
    return mem.exists(a) ? mem[a] : 8'h00;
  endfunction

  always_comb
    dq_i = (!cs_n && we_n && !oe_n && oe_lo_cnt >= RD_EXP) ? mem_rd(m_addr) : 8'hEE;

  always @(negedge clk) if (rst_n) begin
    if (m_addr != p_addr) check(p_cs_n == 1'b1, "R2 addr moved under select", 0, 1);
    if (p_we_n == 1'b0 && we_n == 1'b1) begin
      mem[p_addr] = p_dq;
      check(we_lo_cnt == WP_EXP, "R4 write pulse cycles", we_lo_cnt, WP_EXP);
    end
    if (!we_n) check(oe_n && !cs_n, "R4 oe high/cs low in write", {oe_n, cs_n}, 2);
    check(dq_oe == !we_n, "R5 drive equals write pulse", dq_oe, !we_n);
    if (dq_oe) check(dq_o == wdata, "R5 write byte on bus", dq_o, wdata);
    if (p_oe_n == 1'b0 && oe_n == 1'b1)
      check(oe_lo_cnt == RD_EXP, "R3 oe low cycles", oe_lo_cnt, RD_EXP);
    if (!p_dq_oe && dq_oe) check(oe_hi_cnt >= TA_EXP, "R6 turnaround", oe_hi_cnt, TA_EXP);
    oe_lo_cnt = oe_n ? 0 : oe_lo_cnt + 1;
    we_lo_cnt = we_n ? 0 : we_lo_cnt + 1;
    oe_hi_cnt = !oe_n ? 0 : (oe_hi_cnt < 100 ? oe_hi_cnt + 1 : 100);
    p_cs_n = cs_n; p_we_n = we_n; p_oe_n = oe_n; p_dq_oe = dq_oe;
    p_addr = m_addr; p_dq = dq_o;
  end

  task automatic xact(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] d,
                      output logic [DW-1:0] rd);
    int n;
    int lim;
    rd = '0;
    @(negedge clk);
    req = 1'b1; we = wr; addr = a; wdata = d;
    lim = 0;
    do begin @(negedge clk); lim++; end while (cs_n && lim < 50);
    check(!cs_n, "R7 select never asserted", cs_n, 0);
    check(we_n && oe_n, "R3 setup cycle strobes high", {we_n, oe_n}, 3);
    n = 0;
    do begin @(negedge clk); n++; end while (!ack && n < 50);
    check(n == (wr ? WP_EXP + 1 : RD_EXP + 1), "R7 ack latency", n,
          wr ? WP_EXP + 1 : RD_EXP + 1);
    rd = rdata;
    req = 1'b0;
    @(negedge clk);
    check(!ack, "R7 ack single cycle", ack, 0);
  endtask

  function automatic logic [AW-1:0] addr_of(input int i);
    if (i < AW)   return AW'(1) << i;
    if (i == AW)  return '0;
    if (i == AW+1) return '1;
    return AW'(i * 13577);
  endfunction

  function automatic logic [DW-1:0] data_of(input int i, input logic [AW-1:0] a);
    return a[7:0] ^ {1'b0, a[14:8]} ^ DW'(i * 37);
  endfunction

  initial begin
    logic [DW-1:0] r;
    logic [DW-1:0] last;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(cs_n == 1'b1, "R1 cs_n at reset", cs_n, 1);
    check(we_n == 1'b1, "R1 we_n at reset", we_n, 1);
    check(oe_n == 1'b1, "R1 oe_n at reset", oe_n, 1);
    check(dq_oe == 1'b0, "R1 dq_oe at reset", dq_oe, 0);
    check(ack == 1'b0, "R1 ack at reset", ack, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(cs_n && we_n && oe_n && !dq_oe, "R1 idle after reset", {cs_n, we_n, oe_n, dq_oe}, 14);

    // write sweep then read sweep (R8)
    for (int i = 0; i < NADDR; i++) begin
      logic [AW-1:0] a;
      a = addr_of(i);
      exp_mem[a] = data_of(i, a);
      xact(1'b1, a, data_of(i, a), r);
    end
    for (int i = 0; i < NADDR; i++) begin
      logic [AW-1:0] a;
      a = addr_of(i);
      xact(1'b0, a, '0, r);
      check(r == exp_mem[a], "R8 read-after-write", r, exp_mem[a]);
      check(r == rdata, "R3 rdata held after ack", rdata, r);
    end

    // interleaved: rdata must survive writes (R9)
    for (int i = 0; i < 32; i++) begin
      logic [AW-1:0] a;
      a = AW'(i * 4099 + 7);
      exp_mem[a] = data_of(i + 200, a);
      xact(1'b0, addr_of(i % NADDR), '0, last);
      xact(1'b1, a, exp_mem[a], r);
      check(rdata == last, "R9 rdata stable across write", rdata, last);
      xact(1'b0, a, '0, r);
      check(r == exp_mem[a], "R8 interleaved read", r, exp_mem[a]);
    end

    repeat (3) @(negedge clk);
    check(cs_n && we_n && oe_n && !dq_oe && !ack, "R1 idle at end",
          {cs_n, we_n, oe_n, dq_oe, ack}, 28);
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

  initial begin
    #(CLK_NS * 200000);
    if (!finished) begin
      nfail++;
      $display("FAIL R7 watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
    end
  end

endmodule